// File: doc/BRIEF.md
# Compact Branch Condition Resolver

This unit resolves compact (delay-slot-free) branches and register-indirect jumps for an instruction pipeline. Each cycle it takes a 32-bit instruction word, the address of that instruction and the values of the two source registers named by the word. It decides whether control moves, forms the next fetch address and, for the linking variants, the return address. A branch that resolves as not taken raises a flag saying that the following instruction sits in a forbidden slot. All results come out of registers one clock after the inputs are sampled.

Several branch kinds share one major opcode. They are told apart by comparing the two register field numbers with each other and with zero, not the register contents. A field that names register 0 selects a compare-with-zero form. Equal non-zero fields select a second compare-with-zero form. Any other pairing selects a two-operand compare. Two opcodes use the ordering of the field numbers to pick a branch on signed-add overflow, or on its absence.

Top module: `cbr_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge. Otherwise every output reflects the inputs sampled at the previous rising edge.
- R2: Field positions are: opcode in bits [31:26], first register field (A) in [25:21], second register field (B) in [20:16]. Opcode 110010 is always taken, with next address PC+4+(sign-extended bits [25:0] << 2). Opcode 111010 behaves the same and also links.
- R3: For opcodes 110110 and 111110 with field A != 0, the branch is taken when operand A is zero (110110) or non-zero (111110). The target is PC+4+(sign-extended bits [20:0] << 2).
- R4: For opcodes 110110 and 111110 with field A == 0, the unit jumps unconditionally to operand B + (sign-extended bits [15:0] << 2). Opcode 111110 in this form also links.
- R5: Opcode 010110 selects by field number. With A==0 and B!=0 it branches if operand B <= 0. With A!=0 and A==B it branches if operand B >= 0. Otherwise it branches if A >= B. All three compares are signed.
- R6: Opcode 010111 uses the R5 field rules with operand B > 0, operand B < 0, and A < B. All three compares are signed.
- R7: Opcodes 000110 and 000111 use the R5 and R6 conditions respectively in their two compare-with-zero forms, and those forms link. In the two-operand form the compare is unsigned A >= B (000110) or unsigned A < B (000111), with no link.
- R8: For opcode 001000, field A >= field B branches on signed overflow of operand A + operand B. Otherwise, field A == 0 branches with link if operand B == 0. Otherwise it branches if A == B.
- R9: Opcode 011000 is the complement of R8 in each form. It branches on no overflow, with link if operand B != 0, or if A != B.
- R10: Every taken branch or jump in R2–R9 whose offset field is not named uses PC+4+(sign-extended bits [15:0] << 2), except the R4 jumps, which use their own target. A conditional branch that is not taken outputs next address PC+4 with `fslot_o`=1. Taken branches and jumps have `fslot_o`=0.
- R11: `link_en_o` is 1 for every linking form, whether taken or not, and `link_value_o` is then PC+4. Otherwise both are 0.
- R12: Any other opcode gives `invalid_o`=1, `taken_o`=0, `link_en_o`=0, `fslot_o`=0 and next address PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| opa_i | input | XLEN | Value of the register named by field A |
| opb_i | input | XLEN | Value of the register named by field B |
| taken_o | output | 1 | Control transfer happens |
| next_pc_o | output | XLEN | Next fetch address |
| link_en_o | output | 1 | Instruction writes a return address |
| link_value_o | output | XLEN | Return address (PC+4) when linking |
| fslot_o | output | 1 | Not-taken conditional branch: next instruction is a forbidden slot |
| invalid_o | output | 1 | Opcode is not one this unit resolves |

## Verification
The bench builds the unit with the default XLEN of 32. This makes the signed and unsigned boundaries at 0x7FFFFFFF and 0x80000000 reachable, so the overflow forms and the signed-versus-unsigned split can be driven exactly at their edges. The field-number selection is covered by biasing the random fields towards zero and towards equal values. Full-range offsets of both signs exercise the sign extension of all three offset widths.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam logic [5:0] OP_BR26   = 6'b110010;
  localparam logic [5:0] OP_BR26L  = 6'b111010;
  localparam logic [5:0] OP_EQZJ   = 6'b110110;
  localparam logic [5:0] OP_NEZJ   = 6'b111110;
  localparam logic [5:0] OP_GE_GRP = 6'b010110;
  localparam logic [5:0] OP_LT_GRP = 6'b010111;
  localparam logic [5:0] OP_GE_LNK = 6'b000110;
  localparam logic [5:0] OP_LT_LNK = 6'b000111;
  localparam logic [5:0] OP_EQ_GRP = 6'b001000;
  localparam logic [5:0] OP_NE_GRP = 6'b011000;

  typedef enum logic [3:0] {
    CK_ALWAYS, CK_EQZ, CK_NEZ, CK_LEZ, CK_GEZ, CK_GTZ, CK_LTZ,
    CK_GES, CK_LTS, CK_GEU, CK_LTU, CK_EQ, CK_NE, CK_OV, CK_NOV
  } cond_e;

  typedef enum logic [1:0] {OW_16, OW_21, OW_26} offw_e;

  typedef struct packed {
    logic  valid;     // opcode recognised
    logic  cond_br;   // conditional (may fall through)
    logic  link;      // writes return address
    logic  reg_base;  // target based on operand B
    logic  zsel_a;    // zero compare uses operand A
    offw_e offw;
    cond_e cond;
  } dec_t;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
  import cbr_pkg::*;
(
  input  logic [15:0] hi_i,   // instruction bits [31:16]
  output dec_t        dec_o
);
  logic [5:0] op;
  logic [4:0] fa, fb;
  logic zero_form, self_form;

  assign op = hi_i[15:10];
  assign fa = hi_i[9:5];
  assign fb = hi_i[4:0];
  assign zero_form = (fa == 5'd0) && (fb != 5'd0);
  assign self_form = (fa != 5'd0) && (fa == fb);

  always_comb begin
    dec_o = '{valid: 1'b1, cond_br: 1'b1, link: 1'b0, reg_base: 1'b0,
              zsel_a: 1'b0, offw: OW_16, cond: CK_ALWAYS};
    case (op)
      OP_BR26, OP_BR26L: begin
        dec_o.cond_br = 1'b0;
        dec_o.offw    = OW_26;
        dec_o.link    = (op == OP_BR26L);
      end
      OP_EQZJ, OP_NEZJ: begin
        if (fa != 5'd0) begin
          dec_o.zsel_a = 1'b1;
          dec_o.offw   = OW_21;
          dec_o.cond   = (op == OP_EQZJ) ? CK_EQZ : CK_NEZ;
        end else begin
          dec_o.cond_br  = 1'b0;
          dec_o.reg_base = 1'b1;
          dec_o.link     = (op == OP_NEZJ);
        end
      end
      OP_GE_GRP, OP_GE_LNK: begin
        if (zero_form)      dec_o.cond = CK_LEZ;
        else if (self_form) dec_o.cond = CK_GEZ;
        else                dec_o.cond = (op == OP_GE_GRP) ? CK_GES : CK_GEU;
        dec_o.link = (op == OP_GE_LNK) && (zero_form || self_form);
      end
      OP_LT_GRP, OP_LT_LNK: begin
        if (zero_form)      dec_o.cond = CK_GTZ;
        else if (self_form) dec_o.cond = CK_LTZ;
        else                dec_o.cond = (op == OP_LT_GRP) ? CK_LTS : CK_LTU;
        dec_o.link = (op == OP_LT_LNK) && (zero_form || self_form);
      end
      OP_EQ_GRP, OP_NE_GRP: begin
        if (fa >= fb) begin
          dec_o.cond = (op == OP_EQ_GRP) ? CK_OV : CK_NOV;
        end else if (fa == 5'd0) begin
          dec_o.cond = (op == OP_EQ_GRP) ? CK_EQZ : CK_NEZ;
          dec_o.link = 1'b1;
        end else begin
          dec_o.cond = (op == OP_EQ_GRP) ? CK_EQ : CK_NE;
        end
      end
      default: begin
        dec_o.valid   = 1'b0;
        dec_o.cond_br = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cbr_cond.sv
module cbr_cond
  import cbr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cond_e             cond_i,
  input  logic              zsel_a_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic              hit_o
);
  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] zval, sum;
  logic zneg, zzero, ovf;

  assign zval  = zsel_a_i ? a_i : b_i;
  assign zneg  = zval[MSB];
  assign zzero = (zval == '0);
  assign sum   = a_i + b_i;
  assign ovf   = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);

  always_comb begin
    case (cond_i)
      CK_ALWAYS: hit_o = 1'b1;
      CK_EQZ:    hit_o = zzero;
      CK_NEZ:    hit_o = !zzero;
      CK_LEZ:    hit_o = zneg || zzero;
      CK_GEZ:    hit_o = !zneg;
      CK_GTZ:    hit_o = !zneg && !zzero;
      CK_LTZ:    hit_o = zneg;
      CK_GES:    hit_o = $signed(a_i) >= $signed(b_i);
      CK_LTS:    hit_o = $signed(a_i) <  $signed(b_i);
      CK_GEU:    hit_o = a_i >= b_i;
      CK_LTU:    hit_o = a_i <  b_i;
      CK_EQ:     hit_o = a_i == b_i;
      CK_NE:     hit_o = a_i != b_i;
      CK_OV:     hit_o = ovf;
      CK_NOV:    hit_o = !ovf;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbr_target.sv
module cbr_target
  import cbr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [25:0]       off_i,   // instruction bits [25:0]
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   b_i,
  input  offw_e             offw_i,
  input  logic              reg_base_i,
  input  logic              take_i,
  output logic [XLEN-1:0]   seq_o,
  output logic [XLEN-1:0]   next_o
);
  localparam int SH = 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] o16, o21, o26, off, base;

  assign o16 = {{(XLEN-16-SH){off_i[15]}}, off_i[15:0], {SH{1'b0}}};
  assign o21 = {{(XLEN-21-SH){off_i[20]}}, off_i[20:0], {SH{1'b0}}};
  assign o26 = {{(XLEN-26-SH){off_i[25]}}, off_i[25:0], {SH{1'b0}}};

  always_comb begin
    case (offw_i)
      OW_21:   off = o21;
      OW_26:   off = o26;
      default: off = o16;
    endcase
  end

  assign seq_o  = pc_i + STEP;
  assign base   = reg_base_i ? b_i : seq_o;
  assign next_o = take_i ? (base + off) : seq_o;
endmodule

// File: rtl/cbr_resolver.sv
module cbr_resolver
  import cbr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       instr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   opb_i,
  output logic              taken_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              link_en_o,
  output logic [XLEN-1:0]   link_value_o,
  output logic              fslot_o,
  output logic              invalid_o
);
  dec_t            dec;
  logic            hit, take;
  logic [XLEN-1:0] seq, nxt;

  cbr_decode u_dec (.hi_i(instr_i[31:16]), .dec_o(dec));

  cbr_cond #(.XLEN(XLEN)) u_cond (
    .cond_i(dec.cond), .zsel_a_i(dec.zsel_a),
    .a_i(opa_i), .b_i(opb_i), .hit_o(hit)
  );

  assign take = dec.valid && (!dec.cond_br || hit);

  cbr_target #(.XLEN(XLEN)) u_tgt (
    .off_i(instr_i[25:0]), .pc_i(pc_i), .b_i(opb_i),
    .offw_i(dec.offw), .reg_base_i(dec.reg_base), .take_i(take),
    .seq_o(seq), .next_o(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o      <= 1'b0;
      next_pc_o    <= '0;
      link_en_o    <= 1'b0;
      link_value_o <= '0;
      fslot_o      <= 1'b0;
      invalid_o    <= 1'b0;
    end else begin
      taken_o      <= take;
      next_pc_o    <= nxt;
      link_en_o    <= dec.valid && dec.link;
      link_value_o <= (dec.valid && dec.link) ? seq : '0;
      fslot_o      <= dec.valid && dec.cond_br && !hit;
      invalid_o    <= !dec.valid;
    end
  end

  // Marks edges whose outputs came from inputs sampled out of reset.
  logic live_q;
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  assert_invalid_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    invalid_o |-> (!taken_o && !link_en_o && !fslot_o));

  assert_fslot_not_taken_R10: assert property (@(posedge clk) disable iff (rst)
    fslot_o |-> (!taken_o && !invalid_o));

  assert_fallthrough_R10: assert property (@(posedge clk) disable iff (rst)
    (live_q && !taken_o) |-> (next_pc_o == $past(pc_i) + XLEN'(4)));

  assert_link_value_R11: assert property (@(posedge clk) disable iff (rst)
    (live_q && link_en_o) |-> (link_value_o == $past(pc_i) + XLEN'(4)));

  assert_nolink_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !link_en_o |-> (link_value_o == '0));

  assert_uncond_taken_R2: assert property (@(posedge clk) disable iff (rst)
    (live_q && ($past(instr_i[31:26]) == OP_BR26)) |-> (taken_o && !fslot_o));
endmodule

// File: tb/cbr_resolver_bench.sv
module cbr_resolver_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND = 3000;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] instr = '0, pc = '0, opa = '0, opb = '0;
  logic taken, link_en, fslot, invalid;
  logic [31:0] next_pc, link_value;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbr_resolver #(.XLEN(32)) u_cbr_resolver (
    .clk(clk), .rst(rst), .instr_i(instr), .pc_i(pc), .opa_i(opa), .opb_i(opb),
    .taken_o(taken), .next_pc_o(next_pc), .link_en_o(link_en),
    .link_value_o(link_value), .fslot_o(fslot), .invalid_o(invalid)
  );

  typedef struct packed {
    logic        tk;
    logic [31:0] nxt;
    logic        lk;
    logic [31:0] lv;
    logic        fs;
    logic        inv;
  } exp_t;

  function automatic exp_t model(logic [31:0] w, logic [31:0] p,
                                 logic [31:0] a, logic [31:0] b);
    exp_t e;
    logic [5:0] op = w[31:26];
    logic [4:0] fa = w[25:21];
    logic [4:0] fb = w[20:16];
    logic [31:0] p4 = p + 32'd4;
    logic [31:0] s16 = {{14{w[15]}}, w[15:0], 2'b00};
    logic [31:0] s21 = {{9{w[20]}}, w[20:0], 2'b00};
    logic [31:0] s26 = {{4{w[25]}}, w[25:0], 2'b00};
    logic [31:0] sum = a + b;
    logic ov = (a[31] == b[31]) && (sum[31] != a[31]);
    logic zf = (fa == 0) && (fb != 0);
    logic sf = (fa != 0) && (fa == fb);
    logic c = 1'b0;
    logic isc = 1'b1;
    logic [31:0] off = s16;
    e = '0;
    e.nxt = p4;
    case (op)
      6'b110010, 6'b111010: begin
        isc = 0; e.tk = 1; e.nxt = p4 + s26; e.lk = (op == 6'b111010);
      end
      6'b110110, 6'b111110: begin
        if (fa != 0) begin
          c = (op == 6'b110110) ? (a == 0) : (a != 0); off = s21;
        end else begin
          isc = 0; e.tk = 1; e.nxt = b + s16; e.lk = (op == 6'b111110);
        end
      end
      6'b010110, 6'b000110: begin
        if (zf)      c = $signed(b) <= 0;
        else if (sf) c = $signed(b) >= 0;
        else         c = (op == 6'b010110) ? ($signed(a) >= $signed(b)) : (a >= b);
        e.lk = (op == 6'b000110) && (zf || sf);
      end
      6'b010111, 6'b000111: begin
        if (zf)      c = $signed(b) > 0;
        else if (sf) c = $signed(b) < 0;
        else         c = (op == 6'b010111) ? ($signed(a) < $signed(b)) : (a < b);
        e.lk = (op == 6'b000111) && (zf || sf);
      end
      6'b001000: begin
        if (fa >= fb)     c = ov;
        else if (fa == 0) begin c = (b == 0); e.lk = 1; end
        else              c = (a == b);
      end
      6'b011000: begin
        if (fa >= fb)     c = !ov;
        else if (fa == 0) begin c = (b != 0); e.lk = 1; end
        else              c = (a != b);
      end
      default: begin isc = 0; e.inv = 1; end
    endcase
    if (isc) begin
      e.tk = c; e.fs = !c; e.nxt = c ? (p4 + off) : p4;
    end
    e.lv = e.lk ? p4 : 32'd0;
    return e;
  endfunction

  function automatic string tag_of(logic [31:0] w);
    case (w[31:26])
      6'b110010, 6'b111010: return "R2";
      6'b110110, 6'b111110: return (w[25:21] != 0) ? "R3" : "R4";
      6'b010110: return "R5";
      6'b010111: return "R6";
      6'b000110, 6'b000111: return "R7";
      6'b001000: return "R8";
      6'b011000: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b);
    exp_t e = model(w, p, a, b);
    string t = tag_of(w);
    instr = w; pc = p; opa = a; opb = b;
    @(posedge clk);
    @(negedge clk);
    check({taken, next_pc} === {e.tk, e.nxt}, t, {31'd0, taken, next_pc}, {31'd0, e.tk, e.nxt});
    check(fslot === e.fs, "R10", {63'd0, fslot}, {63'd0, e.fs});
    check({link_en, link_value} === {e.lk, e.lv}, "R11", {31'd0, link_en, link_value}, {31'd0, e.lk, e.lv});
    check(invalid === e.inv, "R12", {63'd0, invalid}, {63'd0, e.inv});
  endtask

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] fa,
                                     logic [4:0] fb, logic [15:0] imm);
    return {op, fa, fb, imm};
  endfunction

  function automatic logic [31:0] pick_val();
    case ($urandom % 7)
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [5:0] pick_op();
    case ($urandom % 12)
      0: return 6'b110010;  1: return 6'b111010;
      2: return 6'b110110;  3: return 6'b111110;
      4: return 6'b010110;  5: return 6'b010111;
      6: return 6'b000110;  7: return 6'b000111;
      8: return 6'b001000;  9: return 6'b011000;
      default: return 6'($urandom);
    endcase
  endfunction

  initial begin
    int unsigned seed0;
    seed0 = $urandom(32'd20240611);
    // R1: reset dominates nonzero inputs
    instr = mk(6'b111010, 5'd3, 5'd4, 16'h0010);
    pc = 32'h0000_1000; opa = 32'd5; opb = 32'd6;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({taken, next_pc, link_en, link_value, fslot, invalid} === '0, "R1",
          {31'd0, taken, next_pc}, 64'd0);
    check({link_en, link_value, fslot, invalid} === '0, "R1",
          {29'd0, link_en, fslot, invalid, link_value}, 64'd0);
    rst = 1'b0;

    // Directed corners
    apply(mk(6'b110010, 5'h1F, 5'h1F, 16'hFFFF), 32'h0000_2000, 0, 0);       // R2 negative 26-bit
    apply(mk(6'b111010, 5'h00, 5'h00, 16'h0001), 32'h0000_2000, 0, 0);       // R2 link
    apply(mk(6'b110110, 5'd7, 5'h10, 16'h0000), 32'h100, 32'd0, 32'd9);      // R3 negative 21-bit, taken
    apply(mk(6'b111110, 5'd7, 5'h00, 16'h0004), 32'h100, 32'd0, 32'd9);      // R3 not taken
    apply(mk(6'b111110, 5'd0, 5'd9, 16'hFFFE), 32'h100, 32'd1, 32'h4000);    // R4 link jump
    apply(mk(6'b001000, 5'd3, 5'd2, 16'h0008), 32'h40, 32'h7FFF_FFFF, 32'd1);       // R8 overflow
    apply(mk(6'b001000, 5'd3, 5'd2, 16'h0008), 32'h40, 32'h8000_0000, 32'h8000_0000); // R8 overflow
    apply(mk(6'b001000, 5'd3, 5'd2, 16'h0008), 32'h40, 32'hFFFF_FFFF, 32'd1);       // R8 no overflow
    apply(mk(6'b001000, 5'd0, 5'd0, 16'h0008), 32'h40, 32'd0, 32'd0);        // R8 fields 0,0: overflow form
    apply(mk(6'b001000, 5'd0, 5'd5, 16'h0008), 32'h40, 32'd0, 32'd0);        // R8 link eq-zero
    apply(mk(6'b011000, 5'd6, 5'd6, 16'h0008), 32'h40, 32'h4000_0000, 32'h4000_0000); // R9 overflow, not taken
    apply(mk(6'b011000, 5'd0, 5'd5, 16'h0008), 32'h40, 32'd0, 32'd0);        // R9 link, not taken
    apply(mk(6'b010110, 5'd4, 5'd5, 16'h0002), 32'h80, 32'h8000_0000, 32'd1); // R5 signed not taken
    apply(mk(6'b000110, 5'd4, 5'd5, 16'h0002), 32'h80, 32'h8000_0000, 32'd1); // R7 unsigned taken
    apply(mk(6'b000111, 5'd0, 5'd5, 16'h0002), 32'h80, 32'd0, 32'd0);        // R7 link, gtz not taken
    apply(mk(6'b010111, 5'd5, 5'd5, 16'h0002), 32'h80, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R6 ltz taken
    apply(mk(6'b111111, 5'd1, 5'd2, 16'h0003), 32'h80, 32'd1, 32'd2);        // R12

    // Constrained random
    for (int i = 0; i < NRAND; i++) begin
      logic [4:0] fa, fb;
      logic [31:0] w;
      fb = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      case ($urandom % 4)
        0: fa = 5'd0;
        1: fa = fb;
        default: fa = 5'($urandom);
      endcase
      w = {pick_op(), fa, fb, 16'($urandom)};
      apply(w, {$urandom} & 32'hFFFF_FFFC, pick_val(), pick_val());
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule